// File: doc/BRIEF.md
# PWM Time-Averaging Duty Estimator

This block turns a raw, asynchronous single-bit PWM level into one fixed-point duty figure per simulation step of a real-time converter model. The PWM is sampled on every fast clock after a two-stage synchronizer. A saturating counter adds up the clocks in which the level was high. At each step boundary the total is captured, multiplied by a precomputed reciprocal gain, and presented as a value between 0 and 1. The model therefore sees the fraction of the step that the switch was on, and a switching edge that falls between two step boundaries still affects the result.

The step boundary comes either from an internal divider that fires every K clocks or from an external strobe input, chosen by a parameter. The result is a signed 32-bit word with 22 fractional bits, qualified by a single-cycle valid pulse. The word holds its value between pulses.

Top module: `pwm_duty_averager`

## Requirements
- R1: The PWM input passes through two flip-flops. A level present at rising edge n is counted at rising edge n+2, and this latency does not depend on the input.
- R2: Within a step, the count rises by exactly one for each clock in which the synchronized PWM is high, and stays unchanged for each clock in which it is low.
- R3: The count of a step saturates at K. A step longer than K clocks, which can only come from the external strobe, therefore never reports more than K high samples.
- R4: For a captured count c, the output is min(2^22, (c*G + 2^15) >> 16) with G = floor((2^38 + floor(K/2)) / K). The output is signed Q10.22 in bits [31:0]. An all-high step gives exactly 0x0040_0000 and an all-low step gives 0.
- R5: The sample taken at the boundary edge belongs to the step that ends there. The next step counts only the samples taken after that edge.
- R6: With the internal divider selected, a boundary occurs every K clocks, the first at the K-th rising edge after reset is released, and the strobe input has no effect.
- R7: With the external strobe selected, every rising edge at which the strobe is high is a boundary. Back-to-back strobes produce steps of one sample each.
- R8: Each boundary produces one duty_valid cycle with the new duty_out. Both appear after the first rising edge that follows the boundary edge.
- R9: Reset clears duty_out to 0 and duty_valid to 0. Between valid cycles, duty_out holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Raw PWM level, asynchronous to clk |
| step_strobe | input | 1 | Step boundary request; used only when the external strobe is selected |
| duty_out | output | 32 | Averaged duty, signed Q10.22, range 0 to 1.0 |
| duty_valid | output | 1 | One-cycle pulse marking a new duty_out |

## Verification
A wrong count, a lost or doubled boundary sample, or a synchronizer with the wrong depth shows up as a duty_out word that differs from the golden value by one or more gain steps. It appears in the first valid cycle after the affected boundary. Random PWM phases and periods move the edges onto every position relative to the boundary, so the depth error cannot hide. A misplaced boundary or a stuck valid shows up as a valid pulse at the wrong distance from the expected boundary, or as no pulse at all, within one step. A bad normalization gain shows up at once in the directed all-high step, which must read exactly 1.0.

// File: rtl/duty_avg_pkg.sv
package duty_avg_pkg;

    // Extra gain bits kept below the output LSB, removed by rounding.
    localparam int GUARD_BITS = 16;

    // Source of the step boundary.
    typedef enum logic {
        STEP_INTERNAL = 1'b0,
        STEP_EXTERNAL = 1'b1
    } step_src_e;

    // Width that holds every count from 0 up to k.
    function automatic int count_width(input int k);
        return (k < 1) ? 1 : $clog2(k + 1);
    endfunction

endpackage

// File: rtl/duty_avg_sync.sv
module duty_avg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    localparam int SW = (STAGES < 2) ? 2 : STAGES;

    logic [SW-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[SW-2:0], async_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_out = chain_q[SW-1];
endmodule

// File: rtl/duty_avg_stepgen.sv
module duty_avg_stepgen
    import duty_avg_pkg::*;
#(
    parameter int        K       = 10,
    parameter step_src_e STEP_SRC = STEP_INTERNAL
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_in,
    output logic step_end
);
    generate
        if (STEP_SRC == STEP_INTERNAL) begin : g_divider
            localparam int TICK_W = (K > 1) ? $clog2(K) : 1;
            localparam logic [TICK_W-1:0] LAST = TICK_W'(K - 1);

            typedef struct packed {
                logic [TICK_W-1:0] tick;
            } div_state_t;

            div_state_t st_d, st_q;
            logic       unused_strobe;

            assign unused_strobe = strobe_in;
            assign step_end      = (st_q.tick == LAST);

            always_comb begin
                st_d = st_q;
                if (step_end) st_d.tick = '0;
                else          st_d.tick = st_q.tick + 1'b1;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            if (K > 1) begin : g_gap_chk
                // R6: internal boundaries are never adjacent when K > 1
                assert_step_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
                    step_end |=> !step_end);
            end
        end else begin : g_strobe
            assign step_end = strobe_in;
        end
    endgenerate
endmodule

// File: rtl/duty_avg_accum.sv
module duty_avg_accum #(
    parameter int K     = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample,
    input  logic             step_end,
    output logic [CNT_W-1:0] cap_count,
    output logic             cap_valid
);
    localparam logic [CNT_W:0] LIMIT = (CNT_W + 1)'(K);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] cap;
        logic             capv;
    } acc_state_t;

    acc_state_t     st_d, st_q;
    logic [CNT_W:0] sum;
    logic [CNT_W:0] sat;

    always_comb begin
        sum = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, sample};
        sat = (sum > LIMIT) ? LIMIT : sum;
        st_d = st_q;
        if (step_end) begin
            // The boundary sample closes the current step.
            st_d.cap  = sat[CNT_W-1:0];
            st_d.capv = 1'b1;
            st_d.cnt  = '0;
        end else begin
            st_d.capv = 1'b0;
            st_d.cnt  = sat[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cap_count = st_q.cap;
    assign cap_valid = st_q.capv;

    // R3: running count never exceeds the step size
    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(K));
    // R3: captured totals are bounded too
    assert_cap_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |-> (cap_count <= CNT_W'(K)));
    // R5: a new step starts from nothing, at most the first sample after the boundary
    assert_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
        step_end |=> (st_q.cnt <= CNT_W'(1)));
endmodule

// File: rtl/duty_avg_norm.sv
module duty_avg_norm
    import duty_avg_pkg::*;
#(
    parameter int K      = 10,
    parameter int CNT_W  = 4,
    parameter int OUT_W  = 32,
    parameter int FRAC_W = 22
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CNT_W-1:0]        cap_count,
    input  logic                    cap_valid,
    output logic signed [OUT_W-1:0] duty,
    output logic                    duty_valid
);
    localparam int GX     = GUARD_BITS;
    localparam int GAIN_W = FRAC_W + GX + 1;
    localparam int PROD_W = CNT_W + GAIN_W;
    localparam logic [63:0] GAIN64 =
        ((64'd1 << (FRAC_W + GX)) + 64'(K / 2)) / 64'(K);
    localparam logic [GAIN_W-1:0] GAIN = GAIN64[GAIN_W-1:0];
    localparam logic [PROD_W-1:0] HALF = PROD_W'(1) << (GX - 1);
    localparam logic [PROD_W-1:0] ONE_P = PROD_W'(1) << FRAC_W;
    localparam logic [OUT_W-1:0]  ONE_O = OUT_W'(1) << FRAC_W;

    typedef struct packed {
        logic [OUT_W-1:0] duty;
        logic             vld;
    } norm_state_t;

    norm_state_t       st_d, st_q;
    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] scaled;

    always_comb begin
        prod   = PROD_W'(cap_count) * PROD_W'(GAIN);
        scaled = (prod + HALF) >> GX;
        st_d     = st_q;
        st_d.vld = cap_valid;
        if (cap_valid) begin
            st_d.duty = (scaled > ONE_P) ? ONE_O : OUT_W'(scaled);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign duty       = st_q.duty;
    assign duty_valid = st_q.vld;

    // R4: the result never leaves the 0..1.0 range
    assert_duty_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |-> (duty >= 0 && duty <= $signed(ONE_O)));
    // R4: a saturated step reads exactly one
    assert_full_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_valid && cap_count == CNT_W'(K)) |=> (duty == $signed(ONE_O)));
    // R8: every capture yields a valid output on the next edge
    assert_valid_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_valid |=> duty_valid);
endmodule

// File: rtl/pwm_duty_averager.sv
module pwm_duty_averager
    import duty_avg_pkg::*;
#(
    parameter int        K           = 10,
    parameter int        SYNC_STAGES = 2,
    parameter int        OUT_W       = 32,
    parameter int        FRAC_W      = 22,
    parameter step_src_e STEP_SRC    = STEP_INTERNAL
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pwm_in,
    input  logic                    step_strobe,
    output logic signed [OUT_W-1:0] duty_out,
    output logic                    duty_valid
);
    localparam int CNT_W = count_width(K);

    logic             pwm_s;
    logic             step_end;
    logic [CNT_W-1:0] cap_count;
    logic             cap_valid;

    duty_avg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pwm_in),
        .sync_out (pwm_s)
    );

    duty_avg_stepgen #(.K(K), .STEP_SRC(STEP_SRC)) u_step (
        .clk       (clk),
        .rst_n     (rst_n),
        .strobe_in (step_strobe),
        .step_end  (step_end)
    );

    duty_avg_accum #(.K(K), .CNT_W(CNT_W)) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (pwm_s),
        .step_end  (step_end),
        .cap_count (cap_count),
        .cap_valid (cap_valid)
    );

    duty_avg_norm #(.K(K), .CNT_W(CNT_W), .OUT_W(OUT_W), .FRAC_W(FRAC_W)) u_norm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cap_count  (cap_count),
        .cap_valid  (cap_valid),
        .duty       (duty_out),
        .duty_valid (duty_valid)
    );

    // R9: the output word only moves together with a valid pulse
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !duty_valid |-> $stable(duty_out));
    // R8: a valid pulse is always caused by a boundary two edges earlier
    assert_valid_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        duty_valid |-> $past(cap_valid));
endmodule

// File: tb/pwm_duty_averager_tb.sv
`timescale 1ns/1ps
module pwm_duty_averager_tb;
    import duty_avg_pkg::*;

    localparam int K = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwm_a = 1'b0, strobe_a = 1'b0;
    logic pwm_b = 1'b0, strobe_b = 1'b0;
    logic signed [31:0] duty_a, duty_b;
    logic dv_a, dv_b;

    int checks = 0;
    int fails = 0;
    longint cyc = 0;
    string tag_a = "R9";
    string tag_b = "R9";
    bit run_checks = 1'b0;

    always #4 clk = ~clk;

    pwm_duty_averager #(.K(K), .STEP_SRC(STEP_INTERNAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_a), .step_strobe(strobe_a),
        .duty_out(duty_a), .duty_valid(dv_a));

    pwm_duty_averager #(.K(K), .STEP_SRC(STEP_EXTERNAL)) u_dut_ext (
        .clk(clk), .rst_n(rst_n), .pwm_in(pwm_b), .step_strobe(strobe_b),
        .duty_out(duty_b), .duty_valid(dv_b));

    function automatic longint duty_of(input int c);
        longint g, r;
        g = ((64'sd1 <<< 38) + longint'(K / 2)) / longint'(K);
        r = (longint'(c) * g + (64'sd1 <<< 15)) >>> 16;
        if (r > (64'sd1 <<< 22)) r = 64'sd1 <<< 22;
        return r;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Golden model: two-stage delay (R1), saturating count (R2, R3), boundaries (R5, R6, R7)
    int m_s1a, m_s2a, m_acca, m_ticka;
    int m_s1b, m_s2b, m_accb;
    int q_cnt_a[$], q_cnt_b[$];
    longint q_at_a[$], q_at_b[$];

    always @(posedge clk) begin
        int sum;
        if (!rst_n) begin
            m_s1a = 0; m_s2a = 0; m_acca = 0; m_ticka = 0;
            m_s1b = 0; m_s2b = 0; m_accb = 0;
        end else begin
            sum = m_acca + m_s2a;
            if (sum > K) sum = K;
            if (m_ticka == K - 1) begin
                q_cnt_a.push_back(sum); q_at_a.push_back(cyc);
                m_acca = 0; m_ticka = 0;
            end else begin
                m_acca = sum; m_ticka++;
            end
            sum = m_accb + m_s2b;
            if (sum > K) sum = K;
            if (strobe_b) begin
                q_cnt_b.push_back(sum); q_at_b.push_back(cyc);
                m_accb = 0;
            end else begin
                m_accb = sum;
            end
            m_s2a = m_s1a; m_s1a = int'(pwm_a);
            m_s2b = m_s1b; m_s1b = int'(pwm_b);
        end
        cyc++;
    end

    longint last_a = 0, last_b = 0;

    always @(negedge clk) begin
        int c;
        longint at;
        if (rst_n && run_checks) begin
            if (dv_a) begin
                if (q_cnt_a.size() == 0) check(1'b0, "R8 spurious valid (int)", 1, 0);
                else begin
                    c = q_cnt_a.pop_front(); at = q_at_a.pop_front();
                    check(duty_a == duty_of(c), tag_a, duty_a, duty_of(c));
                    check(cyc - at == 2, "R8 latency (int)", cyc - at, 2);
                end
            end else check(duty_a == last_a, "R9 hold (int)", duty_a, last_a);
            if (dv_b) begin
                if (q_cnt_b.size() == 0) check(1'b0, "R8 spurious valid (ext)", 1, 0);
                else begin
                    c = q_cnt_b.pop_front(); at = q_at_b.pop_front();
                    check(duty_b == duty_of(c), tag_b, duty_b, duty_of(c));
                    check(cyc - at == 2, "R8 latency (ext)", cyc - at, 2);
                end
            end else check(duty_b == last_b, "R9 hold (ext)", duty_b, last_b);
        end
        last_a = duty_a;
        last_b = duty_b;
    end

    task automatic tick(input logic pa, input logic sa, input logic pb, input logic sb);
        @(negedge clk);
        pwm_a = pa; strobe_a = sa; pwm_b = pb; strobe_b = sb;
    endtask

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(1234);
        repeat (4) @(negedge clk);
        // R9: reset state
        check(duty_a == 0, "R9 reset duty (int)", duty_a, 0);
        check(dv_a == 0, "R9 reset valid (int)", dv_a, 0);
        check(duty_b == 0, "R9 reset duty (ext)", duty_b, 0);
        check(dv_b == 0, "R9 reset valid (ext)", dv_b, 0);
        @(negedge clk);
        rst_n = 1'b1;
        run_checks = 1'b1;

        // R4: all-low steps, then all-high steps read exactly 1.0
        tag_a = "R4 all-low"; tag_b = "R7 strobe every K";
        for (int i = 0; i < 3 * K; i++) tick(1'b0, 1'b0, 1'b0, (i % K) == K - 1);
        tag_a = "R4 all-high"; tag_b = "R4 all-high";
        for (int i = 0; i < 5 * K; i++) tick(1'b1, 1'b0, 1'b1, (i % K) == K - 1);

        // R5: single high sample walking across the boundary position
        tag_a = "R5 boundary sample"; tag_b = "R5 boundary sample";
        for (int off = 0; off < K + 2; off++)
            for (int i = 0; i < 3 * K; i++)
                tick((i % (K + 1)) == off, 1'b0, (i % K) == off % K, (i % K) == K - 1);

        // R1 R2: periodic PWM with random period, width and phase
        for (int w = 0; w < 60; w++) begin
            int per, hi, ph, len;
            per = 2 + int'($urandom_range(0, 40));
            hi = int'($urandom_range(0, per));
            ph = int'($urandom_range(0, per - 1));
            len = 4 * K + int'($urandom_range(0, 30));
            tag_a = "R1 R2 random-phase PWM"; tag_b = "R1 R7 random-phase PWM";
            for (int i = 0; i < len; i++)
                tick(((i + ph) % per) < hi, 1'b0, ((i + 3 * ph) % per) < hi,
                     $urandom_range(0, K - 1) == 0);
        end

        // R6: strobe toggles on the internal-divider instance must not matter
        tag_a = "R6 strobe ignored"; tag_b = "R2 random bits";
        for (int i = 0; i < 2000; i++)
            tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                 1'($urandom_range(0, 1)), $urandom_range(0, 3) == 0);

        // R3: long gaps between strobes with mostly-high PWM saturate at K
        tag_a = "R2 mostly high"; tag_b = "R3 saturation";
        for (int g = 0; g < 40; g++) begin
            int gap;
            gap = K + int'($urandom_range(1, 25));
            for (int i = 0; i < gap; i++)
                tick($urandom_range(0, 7) != 0, 1'b0, $urandom_range(0, 7) != 0, i == gap - 1);
        end

        // R7: back-to-back strobes give one-sample steps
        tag_a = "R2 random bits"; tag_b = "R7 back-to-back";
        for (int i = 0; i < 300; i++)
            tick(1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 1)), 1'b1);

        // idle tail, drain outputs
        tag_a = "R4 drain"; tag_b = "R7 drain";
        for (int i = 0; i < 3 * K; i++) tick(1'b0, 1'b0, 1'b0, 1'b0);
        check(q_cnt_a.size() <= 1, "R8 pending results (int)", q_cnt_a.size(), 1);
        check(q_cnt_b.size() == 0, "R8 pending results (ext)", q_cnt_b.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule